// File: doc/BRIEF.md
# Hardware Return Stack with Overflow Control

This block keeps the return addresses of a processor core in a small hardware stack of `DEPTH` slots. A push stores the supplied program counter plus a fixed return offset and advances a stack pointer. A pop moves the pointer back by one and drops the top entry. Software may load the pointer directly, and it may overwrite the entry the pointer currently selects. The top entry and the pointer are always visible on the outputs.

Pointer value 0 means the stack is empty, and slots 1 to `DEPTH` hold data. Two sticky status flags record a stack that filled up and a pop from an empty stack. Only a software clear or the power-on reset lowers them. A configuration input selects what happens on these events. When it is set, the block asks the reset controller for a device reset and drops its pointer to 0. When it is clear, the stack saturates at the top slot without overwriting it.

Top module: `hw_ret_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the pointer, both flags, the reset request and every slot. After reset, `tos_o` reads 0.
- R2: A push with the pointer below `DEPTH-1` stores `pc_i + RET_INC` (modulo 2^`PC_W`) in slot pointer+1 and increments the pointer. The new value is on `tos_o` after that edge.
- R3: A pop with the pointer above 0 decrements the pointer. `tos_o` then shows the slot below, and that slot's contents are unchanged.
- R4: With `cfg_rst_en_i` low, the push made at pointer `DEPTH-1` stores into slot `DEPTH`, sets `full_o` and moves the pointer to `DEPTH`. Further pushes leave the pointer at `DEPTH` and leave that slot unchanged.
- R5: With `cfg_rst_en_i` high, the push made at pointer `DEPTH-1` still stores into slot `DEPTH` and sets `full_o`. It also sets the pointer to 0 and requests a reset. `full_o` stays set after that. A push at pointer `DEPTH` behaves the same but writes no slot.
- R6: A pop at pointer 0 sets `unf_o` and keeps the pointer at 0, with `tos_o` reading 0. It requests a reset only when `cfg_rst_en_i` is high.
- R7: Both flags are sticky. `flag_clr_i[0]` clears `full_o` and `flag_clr_i[1]` clears `unf_o`. If a flag is set and cleared in the same cycle, the set wins. No other stimulus lowers a flag.
- R8: `ptr_wr_i` loads `ptr_wdata_i` into the pointer, clamped to `DEPTH`. It takes precedence over a top write, a push and a pop in the same cycle, and those are then ignored.
- R9: `tos_wr_i` without `ptr_wr_i` writes `tos_wdata_i` into the slot the pointer selects, and any push or pop in that cycle is ignored. At pointer 0 the write is ignored.
- R10: A push and a pop in the same cycle perform only the push.
- R11: `rst_req_o` is high for exactly the one cycle that follows each reset-causing event (R5, R6). It never rises when `cfg_rst_en_i` was low in the event cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| pc_i | input | PC_W | Program counter of the call |
| ptr_wr_i | input | 1 | Load the pointer from `ptr_wdata_i` |
| ptr_wdata_i | input | PTR_W | New pointer value |
| tos_wr_i | input | 1 | Overwrite the selected slot |
| tos_wdata_i | input | PC_W | Data for the top write |
| flag_clr_i | input | 2 | Flag clear mask: bit 0 full, bit 1 underflow |
| cfg_rst_en_i | input | 1 | 1: overflow or underflow requests a reset; 0: saturate |
| tos_o | output | PC_W | Contents of the selected slot, 0 at pointer 0 |
| ptr_o | output | PTR_W | Stack pointer |
| full_o | output | 1 | Sticky full flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its defaults: `DEPTH` 31, `PC_W` 21 and `RET_INC` 2, which gives a 5-bit pointer. With these values the full run of 31 pushes from an empty stack fits in a few dozen cycles. This lets the bench check that the flag rises on exactly the last push. The 21-bit counter makes the wrap of the return offset reachable at `pc_i` = 0x1FFFFF. Pointer loads put the stack at slots 30 and 31 directly, so both overflow policies and the set-versus-clear race on the flags are reached without long fills.

// File: rtl/rstk_pkg.sv
// Package for the return stack: the decoded operation of one cycle.
// Assumes that one operation at most takes effect per cycle.
package rstk_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_SETPTR = 3'd3,
        OP_SETTOS = 3'd4
    } rstk_op_e;
endpackage

// File: rtl/rstk_mem.sv
// Slot storage: DEPTH registers addressed 1..DEPTH, one write port and
// one combinational read port. Address 0 reads as zero (empty stack).
// Assumes waddr_i is never 0 when we_i is high.
module rstk_mem #(
    parameter int DEPTH = 31,
    parameter int PC_W  = 21,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [PC_W-1:0]  wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [PC_W-1:0]  rdata_o
);
    logic [PC_W-1:0] slot [1:DEPTH];

    for (genvar g = 1; g <= DEPTH; g++) begin : g_slot
        // One slot register: cleared at reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (we_i && waddr_i == PTR_W'(g)) begin
                slot[g] <= wdata_i;
            end
        end
    end

    // Read mux: select the addressed slot, zero for address 0.
    always_comb begin
        rdata_o = '0;
        for (int i = 1; i <= DEPTH; i++) begin
            if (raddr_i == PTR_W'(i)) rdata_o = slot[i];
        end
    end
endmodule

// File: rtl/rstk_ctrl.sv
// Pointer, flag and reset-request control for the return stack.
// Decodes one operation per cycle (pointer write > top write > push > pop),
// applies the overflow policy chosen by cfg_rst_en_i, and drives the
// slot write port. Assumes the slot storage writes on the same edge.
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH   = 31,
    parameter int PC_W    = 21,
    parameter int RET_INC = 2,
    parameter int PTR_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             ptr_wr_i,
    input  logic [PTR_W-1:0] ptr_wdata_i,
    input  logic             tos_wr_i,
    input  logic [PC_W-1:0]  tos_wdata_i,
    input  logic [1:0]       flag_clr_i,
    input  logic             cfg_rst_en_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             full_o,
    output logic             unf_o,
    output logic             rst_req_o,
    output logic             we_o,
    output logic [PTR_W-1:0] waddr_o,
    output logic [PC_W-1:0]  wdata_o
);
    localparam logic [PTR_W-1:0] TOP      = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_OPN = PTR_W'(DEPTH - 1);

    rstk_op_e         op;
    logic [PTR_W-1:0] ptr_q, ptr_n;
    logic             full_q, unf_q, req_q;
    logic             full_set, unf_set, req_n;
    logic [PC_W-1:0]  ret_addr;

    assign ret_addr = pc_i + PC_W'(RET_INC);

    // Operation decode with fixed priority.
    always_comb begin
        if (ptr_wr_i)      op = OP_SETPTR;
        else if (tos_wr_i) op = OP_SETTOS;
        else if (push_i)   op = OP_PUSH;
        else if (pop_i)    op = OP_POP;
        else               op = OP_IDLE;
    end

    // Next pointer, flag events, reset request and slot write.
    always_comb begin
        ptr_n    = ptr_q;
        full_set = 1'b0;
        unf_set  = 1'b0;
        req_n    = 1'b0;
        we_o     = 1'b0;
        waddr_o  = ptr_q;
        wdata_o  = tos_wdata_i;
        unique case (op)
            OP_SETPTR: begin
                ptr_n = (ptr_wdata_i > TOP) ? TOP : ptr_wdata_i;
            end
            OP_SETTOS: begin
                we_o = (ptr_q != '0);
            end
            OP_PUSH: begin
                wdata_o = ret_addr;
                if (ptr_q < LAST_OPN) begin
                    ptr_n   = ptr_q + 1'b1;
                    we_o    = 1'b1;
                    waddr_o = ptr_q + 1'b1;
                end else begin
                    full_set = 1'b1;
                    if (ptr_q == LAST_OPN) begin
                        we_o    = 1'b1;
                        waddr_o = TOP;
                    end
                    if (cfg_rst_en_i) begin
                        ptr_n = '0;
                        req_n = 1'b1;
                    end else begin
                        ptr_n = TOP;
                    end
                end
            end
            OP_POP: begin
                if (ptr_q != '0) begin
                    ptr_n = ptr_q - 1'b1;
                end else begin
                    unf_set = 1'b1;
                    req_n   = cfg_rst_en_i;
                end
            end
            default: ;
        endcase
    end

    // State registers: set beats clear on the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            full_q <= 1'b0;
            unf_q  <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            ptr_q  <= ptr_n;
            full_q <= full_set | (full_q & ~flag_clr_i[0]);
            unf_q  <= unf_set  | (unf_q  & ~flag_clr_i[1]);
            req_q  <= req_n;
        end
    end

    assign ptr_o     = ptr_q;
    assign full_o    = full_q;
    assign unf_o     = unf_q;
    assign rst_req_o = req_q;
endmodule

// File: rtl/hw_ret_stack.sv
// Top of the hardware return stack: control plus slot storage.
// The top-of-stack output is the slot the pointer selects, zero when empty.
// Assumes a reset controller acts on rst_req_o; rst_n is power-on reset only.
module hw_ret_stack #(
    parameter int DEPTH   = 31,
    parameter int PC_W    = 21,
    parameter int RET_INC = 2,
    parameter int PTR_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             ptr_wr_i,
    input  logic [PTR_W-1:0] ptr_wdata_i,
    input  logic             tos_wr_i,
    input  logic [PC_W-1:0]  tos_wdata_i,
    input  logic [1:0]       flag_clr_i,
    input  logic             cfg_rst_en_i,
    output logic [PC_W-1:0]  tos_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             full_o,
    output logic             unf_o,
    output logic             rst_req_o
);
    logic             we;
    logic [PTR_W-1:0] waddr;
    logic [PC_W-1:0]  wdata;

    rstk_ctrl #(
        .DEPTH(DEPTH), .PC_W(PC_W), .RET_INC(RET_INC), .PTR_W(PTR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
        .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i),
        .tos_wr_i(tos_wr_i), .tos_wdata_i(tos_wdata_i),
        .flag_clr_i(flag_clr_i), .cfg_rst_en_i(cfg_rst_en_i),
        .ptr_o(ptr_o), .full_o(full_o), .unf_o(unf_o),
        .rst_req_o(rst_req_o),
        .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
    );

    rstk_mem #(
        .DEPTH(DEPTH), .PC_W(PC_W), .PTR_W(PTR_W)
    ) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .raddr_i(ptr_o), .rdata_o(tos_o)
    );
endmodule

// File: rtl/rstk_chk.sv
// Checker for the return stack, bound to every hw_ret_stack instance.
// Observes ports only; all properties are disabled while rst_n is low.
module rstk_chk #(
    parameter int DEPTH = 31,
    parameter int PC_W  = 21,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic             ptr_wr_i,
    input logic             tos_wr_i,
    input logic [1:0]       flag_clr_i,
    input logic             cfg_rst_en_i,
    input logic [PC_W-1:0]  tos_o,
    input logic [PTR_W-1:0] ptr_o,
    input logic             full_o,
    input logic             unf_o,
    input logic             rst_req_o
);
    logic plain;
    assign plain = !ptr_wr_i && !tos_wr_i;

    a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && push_i && ptr_o < PTR_W'(DEPTH - 1)) |=> ptr_o == $past(ptr_o) + 1'b1);

    a_r3_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && pop_i && !push_i && ptr_o != '0) |=> ptr_o == $past(ptr_o) - 1'b1);

    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && push_i && !cfg_rst_en_i && ptr_o == PTR_W'(DEPTH))
        |=> (ptr_o == PTR_W'(DEPTH) && $stable(tos_o) && full_o));

    a_r6_empty_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && pop_i && !push_i && ptr_o == '0) |=> (ptr_o == '0 && unf_o && tos_o == '0));

    a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !flag_clr_i[0]) |=> full_o);

    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_o && !flag_clr_i[1]) |=> unf_o);

    a_r11_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(cfg_rst_en_i));

    a_r5_req_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ptr_o == '0);
endmodule

bind hw_ret_stack rstk_chk #(.DEPTH(DEPTH), .PC_W(PC_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .ptr_wr_i(ptr_wr_i), .tos_wr_i(tos_wr_i), .flag_clr_i(flag_clr_i),
    .cfg_rst_en_i(cfg_rst_en_i), .tos_o(tos_o), .ptr_o(ptr_o),
    .full_o(full_o), .unf_o(unf_o), .rst_req_o(rst_req_o)
);

// File: tb/hw_ret_stack_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one operation per cycle, updates a
// model built from the requirements and queues the expected outputs; the
// monitor compares them on the following falling edge.
module hw_ret_stack_tb;
    localparam int DEPTH = 31;
    localparam int PC_W  = 21;
    localparam int PTR_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 0, pop_i = 0, ptr_wr_i = 0, tos_wr_i = 0, cfg_rst_en_i = 0;
    logic [PC_W-1:0]  pc_i = '0, tos_wdata_i = '0;
    logic [PTR_W-1:0] ptr_wdata_i = '0;
    logic [1:0]       flag_clr_i = '0;
    logic [PC_W-1:0]  tos_o;
    logic [PTR_W-1:0] ptr_o;
    logic             full_o, unf_o, rst_req_o;

    always #2.5 clk = ~clk;

    hw_ret_stack u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
        .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i), .tos_wr_i(tos_wr_i),
        .tos_wdata_i(tos_wdata_i), .flag_clr_i(flag_clr_i), .cfg_rst_en_i(cfg_rst_en_i),
        .tos_o(tos_o), .ptr_o(ptr_o), .full_o(full_o), .unf_o(unf_o), .rst_req_o(rst_req_o)
    );

    typedef struct {
        int              ptr;
        logic [PC_W-1:0] tos;
        bit              full, unf, req;
        string           tag;
    } exp_t;

    exp_t            q[$];
    int              n_chk = 0, n_fail = 0;
    bit              done = 0;
    int              m_ptr = 0;
    logic [PC_W-1:0] m_mem [32];
    bit              m_full = 0, m_unf = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: one operation, model update, expected item into the queue.
    task automatic step(input bit psh, input bit pp, input logic [PC_W-1:0] pc,
                        input bit pw, input int pv, input bit tw,
                        input logic [PC_W-1:0] tv, input logic [1:0] clr,
                        input bit en, input string tag);
        exp_t e;
        bit   fs = 0, us = 0, req = 0;
        @(negedge clk);
        push_i = psh; pop_i = pp; pc_i = pc; ptr_wr_i = pw; ptr_wdata_i = PTR_W'(pv);
        tos_wr_i = tw; tos_wdata_i = tv; flag_clr_i = clr; cfg_rst_en_i = en;
        if (pw) begin
            m_ptr = (pv > DEPTH) ? DEPTH : pv;
        end else if (tw) begin
            if (m_ptr != 0) m_mem[m_ptr] = tv;
        end else if (psh) begin
            if (m_ptr < DEPTH - 1) begin
                m_ptr++;
                m_mem[m_ptr] = PC_W'(pc + 2);
            end else begin
                fs = 1;
                if (m_ptr == DEPTH - 1) m_mem[DEPTH] = PC_W'(pc + 2);
                if (en) begin m_ptr = 0; req = 1; end
                else m_ptr = DEPTH;
            end
        end else if (pp) begin
            if (m_ptr != 0) m_ptr--;
            else begin us = 1; req = en; end
        end
        m_full = fs | (m_full & !clr[0]);
        m_unf  = us | (m_unf  & !clr[1]);
        @(posedge clk);
        #1;
        push_i = 0; pop_i = 0; ptr_wr_i = 0; tos_wr_i = 0; flag_clr_i = '0;
        e.ptr = m_ptr; e.tos = (m_ptr == 0) ? '0 : m_mem[m_ptr];
        e.full = m_full; e.unf = m_unf; e.req = req; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input bit en, input string tag);
        step(0, 0, '0, 0, 0, 0, '0, 2'b00, en, tag);
    endtask

    // Monitor: compare queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(int'(ptr_o) == e.ptr, e.tag, "ptr", ptr_o, e.ptr);
                chk(tos_o === e.tos, e.tag, "tos", tos_o, e.tos);
                chk(full_o === e.full, e.tag, "full", full_o, e.full);
                chk(unf_o === e.unf, e.tag, "unf", unf_o, e.unf);
                chk(rst_req_o === e.req, e.tag, "rst_req", rst_req_o, e.req);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while held in reset
        chk(ptr_o == '0 && tos_o == '0 && !full_o && !unf_o && !rst_req_o,
            "R1", "reset outputs", {ptr_o, full_o, unf_o, rst_req_o}, 0);
        rst_n = 1'b1;
        idle(0, "R1");
        // R2: pushes, including the wrap of the return offset
        step(1, 0, 21'h000100, 0, 0, 0, '0, 2'b00, 0, "R2");
        step(1, 0, 21'h1FFFFF, 0, 0, 0, '0, 2'b00, 0, "R2");
        step(1, 0, 21'h002000, 0, 0, 0, '0, 2'b00, 0, "R2");
        // R3: pops back to empty
        step(0, 1, '0, 0, 0, 0, '0, 2'b00, 0, "R3");
        step(0, 1, '0, 0, 0, 0, '0, 2'b00, 0, "R3");
        step(0, 1, '0, 0, 0, 0, '0, 2'b00, 0, "R3");
        // R6: underflow without and with the reset policy
        step(0, 1, '0, 0, 0, 0, '0, 2'b00, 0, "R6");
        idle(0, "R7");
        step(0, 1, '0, 0, 0, 0, '0, 2'b00, 1, "R6_R11");
        idle(1, "R11");
        step(0, 0, '0, 0, 0, 0, '0, 2'b10, 0, "R7");
        // R10: push and pop together
        step(1, 1, 21'h000055, 0, 0, 0, '0, 2'b00, 0, "R10");
        // R9: top write at pointer 1, then at pointer 0
        step(0, 0, '0, 0, 0, 1, 21'h0ABCDE, 2'b00, 0, "R9");
        step(0, 0, '0, 1, 0, 1, 21'h012345, 2'b00, 0, "R8");
        step(0, 0, '0, 0, 0, 1, 21'h0FFFFF, 2'b00, 0, "R9");
        step(0, 0, '0, 1, 1, 0, '0, 2'b00, 0, "R9");
        // R8: pointer load wins over a push
        step(1, 0, 21'h000999, 1, 30, 0, '0, 2'b00, 0, "R8");
        // R4: saturating overflow
        step(1, 0, 21'h000300, 0, 0, 0, '0, 2'b00, 0, "R4");
        step(1, 0, 21'h000400, 0, 0, 0, '0, 2'b00, 0, "R4");
        step(0, 1, '0, 0, 0, 0, '0, 2'b00, 0, "R7");
        step(0, 0, '0, 1, 31, 0, '0, 2'b00, 0, "R8");
        step(1, 0, 21'h000500, 0, 0, 0, '0, 2'b01, 0, "R7");
        step(0, 0, '0, 0, 0, 0, '0, 2'b01, 0, "R7");
        // R5: overflow with the reset policy
        step(0, 0, '0, 1, 30, 0, '0, 2'b00, 1, "R8");
        step(1, 0, 21'h000777, 0, 0, 0, '0, 2'b00, 1, "R5_R11");
        idle(1, "R5");
        step(0, 0, '0, 1, 31, 0, '0, 2'b00, 1, "R5");
        step(0, 0, '0, 1, 0, 0, '0, 2'b01, 1, "R7");
        // R5: full flag rises on exactly the last of DEPTH pushes
        for (int k = 0; k < DEPTH; k++) begin
            step(1, 0, PC_W'(k * 16), 0, 0, 0, '0, 2'b00, 1, "R5");
        end
        idle(1, "R11");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule